// File: doc/BRIEF.md
# Multiple-Transfer Register Interlock Scoreboard

This block tracks register hazards left behind by an in-flight load-multiple or store-multiple, so that later instructions that do not touch those registers can keep issuing. When a multiple transfer issues, every register in its list gets its own lock slot. Each slot is loaded with a countdown taken from the register's position in the list and from whether the first address was 64-bit aligned. The slot then counts down to free. A load-multiple places read locks: the register has not yet been loaded. A store-multiple places write locks: the register has not yet been stored.

Each cycle, the sequencer offers a candidate instruction. The candidate gives its two source fields, its destination field, its class and, for a multiple, its register list. The block answers with a combinational stall. List order is ascending register index, so the lowest-numbered listed register has position 0.

Each slot is a three-state machine:
- `SLOT_FREE`: no lock.
- `SLOT_RD_LOCK`: a load is pending.
- `SLOT_WR_LOCK`: a store is pending.

Its transitions are:
- *arm*: FREE to a lock state, on an issue hit with a nonzero countdown.
- *extend*: the lock is kept and the longer countdown wins, on a same-kind hit.
- *retype*: the lock kind is replaced, on an opposite-kind hit.
- *expire*: back to FREE when the count reaches zero.
- *flush*: any state to FREE, on reset or flush.

Top module: `mxfer_interlock`

## Requirements
- R1: Reset or a one-cycle `flush` pulse clears every lock, so that from the next cycle no candidate stalls. Flush has priority over an issue in the same cycle.
- R2: Load-multiple, aligned start: the register at list position k is read-locked for 3 + floor(k/2) cycles. The issue cycle is cycle 0, and a reader stalls in cycles c < latency.
- R3: Load-multiple, unaligned start: the read-lock latency at position k is 3 + floor((k+1)/2).
- R4: Store-multiple, aligned start: the write-lock latency at position k is 1 + floor((k+1)/2), giving 1,2,2,3,3,4,4 for the first seven positions.
- R5: Store-multiple, unaligned start: the write-lock latency is 1 at k=0, 2 at k=1 and k=2, and 2 + floor(k/2) for k >= 3, giving 1,2,2,3,4,4,5 for the first seven positions.
- R6: Only dependent candidates stall. Reading a write-locked register, writing a read-locked register, and touching unlisted registers never stall.
- R7: A store-multiple candidate (`cand_kind` = 2) stalls while any register in `cand_list` is read-locked.
- R8: A load-multiple candidate (`cand_kind` = 1) stalls while any register in `cand_list` is write-locked.
- R9: A plain candidate (`cand_kind` = 0 or 3) stalls if an enabled source is read-locked or the enabled destination is write-locked. Source A doubles as the base register of a multiple and is checked for every class.
- R10: When an issue hits a register that already holds a lock of the same kind, the register keeps whichever remaining lock is longer.
- R11: `stall` is low whenever `cand_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clears all locks |
| iss_vld | input | 1 | A multiple transfer issues this cycle |
| iss_store | input | 1 | 1 = store-multiple, 0 = load-multiple |
| iss_aligned | input | 1 | First address 64-bit aligned |
| iss_list | input | NREG | Register list of the issuing transfer |
| cand_vld | input | 1 | Candidate instruction present |
| cand_kind | input | 2 | 0/3 plain, 1 load-multiple, 2 store-multiple |
| cand_src_a | input | log2(NREG) | Source A / base register |
| cand_src_a_en | input | 1 | Source A used |
| cand_src_b | input | log2(NREG) | Source B |
| cand_src_b_en | input | 1 | Source B used |
| cand_dst | input | log2(NREG) | Destination register |
| cand_dst_en | input | 1 | Destination used |
| cand_list | input | NREG | Register list of a multiple candidate |
| stall | output | 1 | Candidate must wait |

## Verification
The stall answer is combinational, while a lock becomes visible one edge after the issue. For an issue in cycle 0, a register of latency L therefore stalls a dependent candidate in cycles 1 through L-1 and releases it in cycle L. The bench counts edges from the issue edge and probes each cycle shortly after the clock edge, stepping through every register as reader and as writer. It compares the result against latencies computed arithmetically from position and alignment. Flush and overlap effects are sampled in the first cycle after the edge that applies them.

// File: rtl/mxi_pkg.sv
package mxi_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE    = 2'd0,
        SLOT_RD_LOCK = 2'd1,
        SLOT_WR_LOCK = 2'd2
    } slot_state_t;

    typedef enum logic [1:0] {
        CAND_PLAIN       = 2'd0,
        CAND_MULTI_LOAD  = 2'd1,
        CAND_MULTI_STORE = 2'd2,
        CAND_RSVD        = 2'd3
    } cand_kind_t;
endpackage

// File: rtl/mxi_lat_gen.sv
module mxi_lat_gen #(
    parameter int NREG = 16,
    parameter int CW   = 4
) (
    input  logic                      iss_store,
    input  logic                      iss_aligned,
    input  logic [NREG-1:0]           iss_list,
    output logic [NREG-1:0][CW-1:0]   lock_val
);
    localparam int PW = $clog2(NREG + 1);

    // countdown loaded at issue = latency - 1 (R2..R5)
    function automatic logic [CW-1:0] lock_of(input int k, input logic st, input logic al);
        int v;
        if (!st)
            v = al ? 3 + k / 2 : 3 + (k + 1) / 2;
        else if (al)
            v = 1 + (k + 1) / 2;
        else
            v = (k == 0) ? 1 : ((k < 3) ? 2 : 2 + k / 2);
        return CW'(v - 1);
    endfunction

    always_comb begin
        logic [PW-1:0] pos;
        pos = '0;
        for (int i = 0; i < NREG; i++) begin
            lock_val[i] = lock_of(int'(pos), iss_store, iss_aligned);
            if (iss_list[i]) pos = pos + 1'b1;
        end
    end
endmodule

// File: rtl/mxi_slot.sv
module mxi_slot
    import mxi_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          hit,
    input  logic          hit_store,
    input  logic [CW-1:0] load_val,
    output logic          rd_lock,
    output logic          wr_lock
);
    slot_state_t   state, state_n;
    logic [CW-1:0] cnt, cnt_n, dec;
    logic          kind_st;

    assign dec = (cnt != '0) ? cnt - 1'b1 : '0;

    always_comb begin
        kind_st = 1'b0;
        cnt_n   = dec;
        unique case (state)
            SLOT_FREE: begin
                cnt_n   = hit ? load_val : '0;
                kind_st = hit_store;
            end
            SLOT_RD_LOCK: begin
                if (hit && !hit_store) cnt_n = (load_val > dec) ? load_val : dec;
                else if (hit)          begin cnt_n = load_val; kind_st = 1'b1; end
            end
            SLOT_WR_LOCK: begin
                kind_st = 1'b1;
                if (hit && hit_store)  cnt_n = (load_val > dec) ? load_val : dec;
                else if (hit)          begin cnt_n = load_val; kind_st = 1'b0; end
            end
            default: cnt_n = '0;
        endcase
        if (cnt_n == '0)  state_n = SLOT_FREE;
        else if (kind_st) state_n = SLOT_WR_LOCK;
        else              state_n = SLOT_RD_LOCK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            state <= SLOT_FREE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        rd_lock = (state == SLOT_RD_LOCK);
        wr_lock = (state == SLOT_WR_LOCK);
    end

    a_r1_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state == SLOT_FREE && cnt == '0));
    a_r10_keeps_longer: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && hit && !hit_store && state == SLOT_RD_LOCK)
        |=> (({1'b0, cnt} + {{CW{1'b0}}, 1'b1}) >= {1'b0, $past(cnt)}));
    a_r2_no_rise_without_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !hit) |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/mxi_hazard.sv
module mxi_hazard
    import mxi_pkg::*;
#(
    parameter int NREG = 16,
    parameter int RW   = 4
) (
    input  logic            cand_vld,
    input  logic [1:0]      cand_kind,
    input  logic [RW-1:0]   cand_src_a,
    input  logic            cand_src_a_en,
    input  logic [RW-1:0]   cand_src_b,
    input  logic            cand_src_b_en,
    input  logic [RW-1:0]   cand_dst,
    input  logic            cand_dst_en,
    input  logic [NREG-1:0] cand_list,
    input  logic [NREG-1:0] rd_lock,
    input  logic [NREG-1:0] wr_lock,
    output logic            stall
);
    logic src_hit, dep;

    always_comb begin
        src_hit = (cand_src_a_en && rd_lock[cand_src_a]) ||
                  (cand_src_b_en && rd_lock[cand_src_b]);
        unique case (cand_kind_t'(cand_kind))
            CAND_MULTI_LOAD:  dep = src_hit || |(cand_list & wr_lock);
            CAND_MULTI_STORE: dep = src_hit || |(cand_list & rd_lock);
            default:          dep = src_hit || (cand_dst_en && wr_lock[cand_dst]);
        endcase
        stall = cand_vld && dep;
    end
endmodule

// File: rtl/mxfer_interlock.sv
module mxfer_interlock #(
    parameter int NREG = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    iss_vld,
    input  logic                    iss_store,
    input  logic                    iss_aligned,
    input  logic [NREG-1:0]         iss_list,
    input  logic                    cand_vld,
    input  logic [1:0]              cand_kind,
    input  logic [$clog2(NREG)-1:0] cand_src_a,
    input  logic                    cand_src_a_en,
    input  logic [$clog2(NREG)-1:0] cand_src_b,
    input  logic                    cand_src_b_en,
    input  logic [$clog2(NREG)-1:0] cand_dst,
    input  logic                    cand_dst_en,
    input  logic [NREG-1:0]         cand_list,
    output logic                    stall
);
    localparam int RW = $clog2(NREG);
    localparam int CW = $clog2(NREG / 2 + 4);

    logic [NREG-1:0][CW-1:0] lock_val;
    logic [NREG-1:0]         rd_lock, wr_lock;

    mxi_lat_gen #(.NREG(NREG), .CW(CW)) u_lat (
        .iss_store(iss_store), .iss_aligned(iss_aligned),
        .iss_list(iss_list), .lock_val(lock_val)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        mxi_slot #(.CW(CW)) u_slot (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .hit(iss_vld && iss_list[i]), .hit_store(iss_store),
            .load_val(lock_val[i]),
            .rd_lock(rd_lock[i]), .wr_lock(wr_lock[i])
        );
    end

    mxi_hazard #(.NREG(NREG), .RW(RW)) u_haz (
        .cand_vld(cand_vld), .cand_kind(cand_kind),
        .cand_src_a(cand_src_a), .cand_src_a_en(cand_src_a_en),
        .cand_src_b(cand_src_b), .cand_src_b_en(cand_src_b_en),
        .cand_dst(cand_dst), .cand_dst_en(cand_dst_en),
        .cand_list(cand_list), .rd_lock(rd_lock), .wr_lock(wr_lock),
        .stall(stall)
    );

    a_r11_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_vld |-> !stall);
    a_r1_no_stall_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !stall);
endmodule

// File: tb/sim_mxfer_interlock.sv
`timescale 1ns/10ps
module sim_mxfer_interlock;
    localparam int N = 16;
    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic iss_vld = 1'b0, iss_store = 1'b0, iss_aligned = 1'b0;
    logic [N-1:0] iss_list = '0, cand_list = '0;
    logic cand_vld = 1'b0, cand_src_a_en = 1'b0, cand_src_b_en = 1'b0, cand_dst_en = 1'b0;
    logic [1:0] cand_kind = 2'd0;
    logic [3:0] cand_src_a = '0, cand_src_b = '0, cand_dst = '0;
    logic stall;
    int checks = 0, errors = 0, cyc = 0;

    mxfer_interlock #(.NREG(N)) u0 (.*);

    always #2.5 clk = ~clk;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic int exp_lat(input int k, input bit st, input bit al);
        if (!st) return al ? 3 + k / 2 : 3 + (k + 1) / 2;
        if (al) return 1 + (k + 1) / 2;
        if (k == 0) return 1;
        if (k < 3) return 2;
        return 2 + k / 2;
    endfunction

    task automatic clear_cand();
        cand_vld = 0; cand_kind = 0; cand_src_a_en = 0; cand_src_b_en = 0;
        cand_dst_en = 0; cand_list = '0;
    endtask

    task automatic probe_read(input int r);
        clear_cand(); cand_vld = 1; cand_src_b = 4'(r); cand_src_b_en = 1; #0.05;
    endtask
    task automatic probe_write(input int r);
        clear_cand(); cand_vld = 1; cand_dst = 4'(r); cand_dst_en = 1; #0.05;
    endtask

    task automatic issue(input logic [N-1:0] l, input bit st, input bit al);
        @(negedge clk); iss_vld = 1; iss_list = l; iss_store = st; iss_aligned = al;
        @(posedge clk); #0.2 iss_vld = 0;
    endtask

    // sweep: every register, as reader and writer, every cycle after issue
    task automatic run_multi(input logic [N-1:0] l, input bit st, input bit al);
        string tg;
        tg = st ? (al ? "R4" : "R5") : (al ? "R2" : "R3");
        issue(l, st, al);
        for (int c = 1; c <= 12; c++) begin
            int k = 0;
            for (int r = 0; r < N; r++) begin
                bit lk = l[r] && (c < exp_lat(k, st, al));
                probe_read(r);
                chk(stall, lk && !st, $sformatf("%s/R6 read r%0d c%0d", tg, r, c));
                probe_write(r);
                chk(stall, lk && st, $sformatf("%s/R6 write r%0d c%0d", tg, r, c));
                if (l[r]) k++;
            end
            clear_cand();
            @(posedge clk); #0.2;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #0.2;
        for (int r = 0; r < N; r++) begin
            probe_read(r);  chk(stall, 1'b0, "R1 reset read");
            probe_write(r); chk(stall, 1'b0, "R1 reset write");
        end
        clear_cand();

        for (int st = 0; st < 2; st++)
            for (int al = 0; al < 2; al++) begin
                for (int n = 1; n <= 8; n++) begin
                    run_multi(N'((1 << n) - 1), st[0], al[0]);
                    run_multi(N'(((1 << n) - 1) << 5), st[0], al[0]);
                end
                run_multi(16'hA5A5, st[0], al[0]);
                run_multi(16'hFFFF, st[0], al[0]);
            end

        // R1: flush clears everything next cycle
        issue(16'hFFFF, 1'b0, 1'b1);
        probe_read(9); chk(stall, 1'b1, "R1 pre-flush locked");
        @(negedge clk); flush = 1; @(posedge clk); #0.2 flush = 0;
        for (int r = 0; r < N; r++) begin
            probe_read(r); chk(stall, 1'b0, "R1 after flush");
        end
        clear_cand(); repeat (12) @(posedge clk); #0.2;

        // R7: store-multiple candidate vs read locks (reg2,3: latency 3)
        issue(16'h000C, 1'b0, 1'b1);
        clear_cand(); cand_vld = 1; cand_kind = 2; cand_list = 16'h0208; #0.05;
        chk(stall, 1'b1, "R7 store list hits load lock");
        cand_list = 16'h0200; #0.05; chk(stall, 1'b0, "R7 store list unlocked");
        // R11: no candidate, no stall
        cand_vld = 0; cand_list = 16'h0008; #0.05; chk(stall, 1'b0, "R11 idle");
        cand_vld = 1; cand_kind = 0; cand_dst = 4'd3; cand_dst_en = 1; #0.05;
        chk(stall, 1'b0, "R9 plain write of read-locked");
        cand_dst_en = 0; cand_src_a = 4'd2; cand_src_a_en = 1; #0.05;
        chk(stall, 1'b1, "R9 plain src_a read-locked");
        @(posedge clk); @(posedge clk); #0.2;     // cycle 3
        clear_cand(); cand_vld = 1; cand_kind = 2; cand_list = 16'h0008; #0.05;
        chk(stall, 1'b0, "R7 store after load done");
        clear_cand(); repeat (12) @(posedge clk); #0.2;

        // R8: load-multiple candidate vs write locks; reg9 at k=5 -> 4
        issue(16'h03F0, 1'b1, 1'b1);
        @(posedge clk); #0.2;                      // cycle 2
        clear_cand(); cand_vld = 1; cand_kind = 1; cand_list = 16'h0200; #0.05;
        chk(stall, 1'b1, "R8 load list hits store lock");
        cand_list = 16'h0001; #0.05; chk(stall, 1'b0, "R8 load list unlocked");
        // R9: base register of a multiple counts as a read
        cand_kind = 3; cand_list = '0; cand_src_a = 4'd9; cand_src_a_en = 1; #0.05;
        chk(stall, 1'b0, "R9 reserved kind read of write-locked");
        @(posedge clk); @(posedge clk); #0.2;      // cycle 4
        clear_cand(); cand_vld = 1; cand_kind = 1; cand_list = 16'h0200; #0.05;
        chk(stall, 1'b0, "R8 load after store done");
        clear_cand(); repeat (12) @(posedge clk); #0.2;

        issue(16'h0040, 1'b0, 1'b1);
        clear_cand(); cand_vld = 1; cand_kind = 2; cand_src_a = 4'd6; cand_src_a_en = 1; #0.05;
        chk(stall, 1'b1, "R9 base of store-multiple read-locked");
        clear_cand(); repeat (12) @(posedge clk); #0.2;

        // R10: later shorter lock does not cut reg7 (first L=6)
        issue(16'h00FF, 1'b0, 1'b1);               // now cycle 1
        issue(16'h0080, 1'b0, 1'b1);               // now cycle 2
        repeat (3) @(posedge clk); #0.2;           // cycle 5
        probe_read(7); chk(stall, 1'b1, "R10 longer kept c5");
        @(posedge clk); #0.2;                      // cycle 6
        probe_read(7); chk(stall, 1'b0, "R10 free c6");
        clear_cand(); repeat (12) @(posedge clk); #0.2;

        // R10: later longer lock extends reg7 (second issue L=6 at cycle 1)
        issue(16'h0080, 1'b0, 1'b1);
        issue(16'h00FF, 1'b0, 1'b1);               // cycle 2
        repeat (4) @(posedge clk); #0.2;           // cycle 6
        probe_read(7); chk(stall, 1'b1, "R10 extended c6");
        @(posedge clk); #0.2;                      // cycle 7
        probe_read(7); chk(stall, 1'b0, "R10 extended free c7");
        clear_cand();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule